// File: doc/BRIEF.md
# Self-Checking Reversible Gate Cell

This block wraps a three-input, three-output reversible gate so that a single bit error on the gate's outputs shows up while the circuit is running. The gate is one of two parity-preserving kinds, picked at elaboration by a parameter. The first is a double controlled-NOT, which copies A and XORs it onto B and onto C. The second is a controlled swap, which passes A through and exchanges B and C when A is set.

A spare testing line enters next to the operational inputs and is tied to zero. The first stage folds it together with the three operands into a testing output. The operational outputs then pass through a second stage, the deduction gate. This stage forwards them unchanged and computes their parity on a second spare line that is also tied to zero. Both gates preserve parity, so the two spare results agree on a healthy cell. Any disagreement raises an active-high error flag.

The wrapped cell is therefore five lines wide, the gate's width plus two. A fault mask sits between the gate and the deduction stage, so a testbench can flip any combination of output bits. The cell is purely combinational.

Top module: `otc_cell`

## Requirements
- R1: With KIND set to the double controlled-NOT variant, and no fault injected, op_out[2] = A, op_out[1] = A xor B and op_out[0] = A xor C, where A = op_in[2], B = op_in[1] and C = op_in[0].
- R2: With KIND set to the controlled-swap variant, and no fault injected, op_out[2] = A, op_out[1] = (!A & B) | (A & C) and op_out[0] = (!A & C) | (A & B).
- R3: test_out equals test_in xor A xor B xor C for every input combination.
- R4: chk_out equals the XOR of the three bits of op_out as delivered, with any injected fault already applied.
- R5: Bit i of fault_mask inverts bit i of op_out relative to the fault-free gate result, for i = 0..2.
- R6: With test_in = 0 and fault_mask = 0, err is 0 for all eight operand patterns in both variants.
- R7: With test_in = 0, any fault_mask with exactly one bit set drives err to 1.
- R8: With test_in = 0, a fault_mask with exactly two bits set leaves err at 0, and a mask with all three bits set drives err to 1.
- R9: With test_in = 1 and fault_mask = 0, err is 1, because a testing input that is not held at zero is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | 3 | Operands: bit 2 = A, bit 1 = B, bit 0 = C |
| test_in | input | 1 | Testing input, held at 0 in normal use |
| fault_mask | input | 3 | Bit i set inverts operational output bit i |
| op_out | output | 3 | Operational outputs, taken after the deduction pass-through |
| test_out | output | 1 | Parity carried forward from the inputs |
| chk_out | output | 1 | Parity re-derived from the operational outputs |
| err | output | 1 | Active-high error flag, set when test_out and chk_out differ |

## Verification
All eight operand patterns are applied to both gate variants. Every pattern is combined with each of the eight fault masks. The all-zero mask confirms the truth tables and shows that a healthy cell never flags. The one-hot masks show that every output position is covered by the check. The two-bit masks show the known blind spot, where errors in pairs go undetected. The full mask shows that a flip of all three bits is seen again. A separate pass with test_in set to 1 and no fault tells a wrongly driven testing line apart from a data fault on the outputs.

// File: rtl/otc_pkg.sv
package otc_pkg;

    typedef enum logic [0:0] {
        GK_FEYNMAN2 = 1'b0,
        GK_FREDKIN  = 1'b1
    } gate_kind_e;

    localparam int unsigned LANES = 3;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } trio_t;

    function automatic trio_t dual_cnot(input trio_t x);
        trio_t y;
        y.a = x.a;
        y.b = x.a ^ x.b;
        y.c = x.a ^ x.c;
        return y;
    endfunction

    function automatic trio_t ctrl_swap(input trio_t x);
        trio_t y;
        y.a = x.a;
        y.b = x.a ? x.c : x.b;
        y.c = x.a ? x.b : x.c;
        return y;
    endfunction

    function automatic logic parity3(input trio_t x);
        return x.a ^ x.b ^ x.c;
    endfunction

endpackage

// File: rtl/otc_testable_gate.sv
module otc_testable_gate
    import otc_pkg::*;
#(
    parameter gate_kind_e KIND = GK_FREDKIN
) (
    input  trio_t ops_i,
    input  logic  tin_i,
    output trio_t ops_o,
    output logic  tout_o
);

    generate
        if (KIND == GK_FEYNMAN2) begin : g_dual
            assign ops_o = dual_cnot(ops_i);
        end else begin : g_swap
            assign ops_o = ctrl_swap(ops_i);
        end
    endgenerate

    assign tout_o = tin_i ^ parity3(ops_i);

    always_comb begin
        AST_GATE_PARITY_KEPT: assert (parity3(ops_o) == parity3(ops_i))
            else $error("gate broke parity"); // R3
        AST_A_PASSES: assert (ops_o.a == ops_i.a)
            else $error("control line altered"); // R1
    end

endmodule

// File: rtl/otc_deduce_gate.sv
module otc_deduce_gate
    import otc_pkg::*;
(
    input  trio_t dat_i,
    input  logic  rin_i,
    output trio_t dat_o,
    output logic  sout_o
);

    assign dat_o  = dat_i;
    assign sout_o = rin_i ^ dat_i.a ^ dat_i.b ^ dat_i.c;

endmodule

// File: rtl/otc_cell.sv
module otc_cell
    import otc_pkg::*;
#(
    parameter gate_kind_e KIND = GK_FREDKIN
) (
    input  logic [2:0] op_in,
    input  logic       test_in,
    input  logic [2:0] fault_mask,
    output logic [2:0] op_out,
    output logic       test_out,
    output logic       chk_out,
    output logic       err
);

    trio_t gate_res;
    trio_t faulty;
    trio_t passed;
    logic  q_par;
    logic  s_par;

    otc_testable_gate #(.KIND(KIND)) u_gate (
        .ops_i  (trio_t'(op_in)),
        .tin_i  (test_in),
        .ops_o  (gate_res),
        .tout_o (q_par)
    );

    assign faulty = trio_t'(gate_res ^ trio_t'(fault_mask));

    otc_deduce_gate u_deduce (
        .dat_i  (faulty),
        .rin_i  (1'b0),
        .dat_o  (passed),
        .sout_o (s_par)
    );

    assign op_out   = passed;
    assign test_out = q_par;
    assign chk_out  = s_par;
    assign err      = q_par ^ s_par;

    always_comb begin
        AST_CHK_TRACKS_OUT: assert (chk_out == ^op_out)
            else $error("chk_out mismatch"); // R4
        if (!test_in && fault_mask == 3'b000)
            AST_CLEAN_SILENT: assert (!err)
                else $error("false alarm"); // R6
        if (!test_in && $countones(fault_mask) == 1)
            AST_SINGLE_CAUGHT: assert (err)
                else $error("single flip missed"); // R7
        if (!test_in && $countones(fault_mask) == 2)
            AST_PAIR_HIDDEN: assert (!err)
                else $error("pair flip flagged"); // R8
        if (test_in && fault_mask == 3'b000)
            AST_TESTLINE_SEEN: assert (err)
                else $error("testing line not seen"); // R9
    end

endmodule

// File: tb/test_otc_cell.sv
module test_otc_cell;
    import otc_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [2:0] op_in = 3'b000;
    logic       test_in = 1'b0;
    logic [2:0] fault_mask = 3'b000;
    logic [2:0] out_d, out_s;
    logic       tq_d, tq_s, ck_d, ck_s, er_d, er_s;

    int total = 0;
    int bad = 0;
    bit done = 0;

    otc_cell #(.KIND(GK_FEYNMAN2)) i_otc_cell (
        .op_in(op_in), .test_in(test_in), .fault_mask(fault_mask),
        .op_out(out_d), .test_out(tq_d), .chk_out(ck_d), .err(er_d));

    otc_cell #(.KIND(GK_FREDKIN)) i_otc_cell_swap (
        .op_in(op_in), .test_in(test_in), .fault_mask(fault_mask),
        .op_out(out_s), .test_out(tq_s), .chk_out(ck_s), .err(er_s));

    // {abc, dual-CNOT result, controlled-swap result}
    localparam logic [8:0] VEC [8] = '{
        {3'b000, 3'b000, 3'b000},
        {3'b001, 3'b001, 3'b001},
        {3'b010, 3'b010, 3'b010},
        {3'b011, 3'b011, 3'b011},
        {3'b100, 3'b111, 3'b100},
        {3'b101, 3'b110, 3'b110},
        {3'b110, 3'b101, 3'b101},
        {3'b111, 3'b100, 3'b111}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // quiescent state with all inputs low
        chk("R6 idle", {out_d, er_d}, 4'b0000);
        chk("R6 idle swap", {out_s, er_s}, 4'b0000);

        for (int v = 0; v < 8; v++) begin
            for (int m = 0; m < 8; m++) begin
                logic [2:0] abc, ed, es, mk;
                logic       par, ee;
                abc = VEC[v][8:6];
                ed  = VEC[v][5:3];
                es  = VEC[v][2:0];
                mk  = 3'(m);
                par = ^abc;
                ee  = ^mk; // one or three flips seen, two hidden
                op_in = abc; fault_mask = mk; test_in = 1'b0;
                @(negedge clk);
                if (m == 0) begin
                    chk("R1 dual-cnot outputs", {1'b0, out_d}, {1'b0, ed});
                    chk("R2 ctrl-swap outputs", {1'b0, out_s}, {1'b0, es});
                    chk("R6 clean no error", {2'b00, er_d, er_s}, 4'b0000);
                end
                chk("R5 mask flips outputs", {1'b0, out_s}, {1'b0, es ^ mk});
                chk("R5 mask flips dual", {1'b0, out_d}, {1'b0, ed ^ mk});
                chk("R3 test_out", {2'b00, tq_d, tq_s}, {2'b00, par, par});
                chk("R4 chk_out", {2'b00, ck_d, ck_s}, {2'b00, ^(ed ^ mk), ^(es ^ mk)});
                if ($countones(mk) == 1)
                    chk("R7 single flip", {2'b00, er_d, er_s}, 4'b0011);
                else if ($countones(mk) == 2)
                    chk("R8 pair hidden", {2'b00, er_d, er_s}, 4'b0000);
                else if ($countones(mk) == 3)
                    chk("R8 triple seen", {2'b00, er_d, er_s}, 4'b0011);
                else
                    chk("R6 err zero", {2'b00, er_d, er_s}, {2'b00, ee, ee});
            end
        end

        for (int v = 0; v < 8; v++) begin
            op_in = VEC[v][8:6]; fault_mask = 3'b000; test_in = 1'b1;
            @(negedge clk);
            chk("R9 testing line high", {2'b00, er_d, er_s}, 4'b0011);
            chk("R3 test_out with test_in", {2'b00, tq_d, tq_s},
                {2'b00, ~(^VEC[v][8:6]), ~(^VEC[v][8:6])});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule